// File: doc/BRIEF.md
# Low-Frequency RC Calibration Scheduler

This block decides when the low-frequency RC oscillator gets recalibrated, and it runs the calibration window. It keeps a 7-bit interval value in quarter-second units. A start request loads the interval into a down-counter. The counter is decremented on a quarter-second tick, which is made by dividing the low-frequency clock period strobe by a parameterised ratio (8192 by default, matching a 32.768 kHz source). When the count reaches zero the block raises a timeout event and stops on its own. A stop request freezes the count.

A calibration request opens a window of fixed length. During the window the block asks for the high-frequency clock as a reference. At the end of the window it signals completion. The result is marked good only if the crystal high-frequency source ran for the whole window.

The three requests (calibrate, start, stop) share one rule: at most one request is accepted in each low-frequency clock period. Anything beyond that is dropped and latches a sticky error flag. Four event sources feed pending flags. Per-bit enable registers, written through separate set and clear strobes, gate those flags onto one interrupt line.

Top module: `lfrc_cal_sched`

## Requirements
- R1: After reset, the count, interval, enables and pending flags are all zero, and ct_running, hf_req, irq, task_err, done_evt and timeout_evt are all low.
- R2: A write strobe stores the 7-bit interval value, which reads back on interval_q. An accepted start request loads that value into ct_count and sets ct_running.
- R3: While the timer runs, every DIV_RATIO low-frequency strobes make one tick, and each tick decrements ct_count. For an interval N of 1 or more, timeout_evt pulses one cycle after the strobe that completes N ticks. Pending bit 4 sets one cycle after that.
- R4: When the timeout fires, ct_running falls and ct_count stays at 0. No further timeout follows until the next start.
- R5: An accepted stop request clears ct_running and holds ct_count at its value. No timeout then follows.
- R6: An interval of 0 gives a timeout on the first tick after the start, the same as an interval of 1.
- R7: After one request has been accepted, any further request before the next low-frequency strobe is ignored and sets task_err. task_err stays high until reset. A request that arrives in the same cycle as a strobe belongs to the new period.
- R8: When several requests arrive in the same cycle, stop wins over start and start wins over calibrate. The losing requests are ignored and set task_err.
- R9: An accepted calibration request raises hf_req from the next cycle for exactly CAL_CYCLES cycles. done_evt pulses in the first cycle after hf_req falls, and pending bit 3 sets one cycle after that.
- R10: cal_ok is updated at each completion. It reads 1 only if hfxo_running was high in every cycle of the window; otherwise it reads 0 and completion is still signalled.
- R11: Enable bits sit at positions 0 (high-frequency started), 1 (low-frequency started), 3 (calibration done) and 4 (timer timeout). Bit 2 is reserved and always reads 0. A 1 written through the set strobe enables a bit, and a 1 written through the clear strobe disables it. If both strobes name the same bit in one cycle, the clear wins.
- R12: irq is high whenever some pending bit and the matching enable bit are both 1. A 1 in evt_clr_mask written with evt_clr_wr clears that pending bit. The started inputs set pending bits 0 and 1 one cycle after their strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_pulse | input | 1 | One-cycle strobe per low-frequency clock period |
| hfxo_running | input | 1 | Crystal high-frequency source is running |
| hf_started_in | input | 1 | High-frequency started event strobe |
| lf_started_in | input | 1 | Low-frequency started event strobe |
| task_cal | input | 1 | Calibration request strobe |
| task_ct_start | input | 1 | Timer start request strobe |
| task_ct_stop | input | 1 | Timer stop request strobe |
| interval_wr | input | 1 | Interval register write strobe |
| interval_wdata | input | 7 | Interval value in quarter seconds |
| inten_set_wr | input | 1 | Enable-set write strobe |
| inten_clr_wr | input | 1 | Enable-clear write strobe |
| inten_wdata | input | 5 | Bit mask for enable set/clear |
| evt_clr_wr | input | 1 | Pending-clear write strobe |
| evt_clr_mask | input | 5 | Bit mask of pending flags to clear |
| interval_q | output | 7 | Stored interval value |
| ct_count | output | 7 | Current timer count |
| ct_running | output | 1 | Timer is counting |
| timeout_evt | output | 1 | One-cycle timeout pulse |
| hf_req | output | 1 | High-frequency reference request during calibration |
| done_evt | output | 1 | One-cycle calibration completion pulse |
| cal_ok | output | 1 | Last calibration had the crystal for the whole window |
| inten | output | 5 | Interrupt enable bits |
| pending | output | 5 | Pending event flags |
| irq | output | 1 | Interrupt line |
| task_err | output | 1 | Sticky request-rule violation flag |

## Verification
A wrong divider phase or a missed reload shows up as a timeout that lands a whole number of strobes early or late. The bench counts strobes from the start request to the pending timeout bit, so the error is visible within one interval. A period flag that stays set or clears too early shows up on the next request as a spurious or missing task_err, and as a count that did or did not change. A window counter that is off by one changes the measured hf_req length at once. A dropped crystal-status sample is seen in cal_ok as soon as the window closes.

// File: rtl/lfrc_cal_pkg.sv
package lfrc_cal_pkg;
   localparam int EVT_W        = 5;
   localparam int BIT_HF_START = 0;
   localparam int BIT_LF_START = 1;
   localparam int BIT_CAL_DONE = 3;
   localparam int BIT_TIMEOUT  = 4;
   // bits that carry real flops; bit 2 is reserved
   localparam logic [EVT_W-1:0] EVT_IMPL = 5'b11011;

   typedef struct packed {
      logic stop;
      logic start;
      logic cal;
   } task_vec_t;
endpackage

// File: rtl/lfrc_task_gate.sv
module lfrc_task_gate
   import lfrc_cal_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lf_pulse,
   input  task_vec_t req,
   output task_vec_t grant,
   output logic      err
);
   logic used_q;
   logic err_q;
   logic period_busy;
   logic any_req;
   logic any_grant;
   logic multi_req;

   // a strobe in the same cycle opens a fresh period
   assign period_busy = used_q & ~lf_pulse;
   assign any_req     = |req;
   assign any_grant   = |grant;
   assign multi_req   = (req.stop & req.start) | (req.stop & req.cal) | (req.start & req.cal);

   always_comb begin
      grant = '0;
      if (!period_busy) begin
         if (req.stop)       grant.stop  = 1'b1;
         else if (req.start) grant.start = 1'b1;
         else if (req.cal)   grant.cal   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         used_q <= lf_pulse ? any_grant : (used_q | any_grant);
         err_q  <= err_q | (any_req & period_busy) | multi_req;
      end
   end

   assign err = err_q;

   // R7
   period_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_grant |=> (!any_grant || lf_pulse));
   // R7
   late_req_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_req && used_q && !lf_pulse) |=> err_q);
   // R8
   clash_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      multi_req |=> err_q);
endmodule

// File: rtl/lfrc_interval_timer.sv
module lfrc_interval_timer #(
   parameter int IV_W      = 7,
   parameter int DIV_RATIO = 8192
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lf_pulse,
   input  logic            iv_wr,
   input  logic [IV_W-1:0] iv_wdata,
   input  logic            go,
   input  logic            halt,
   output logic [IV_W-1:0] iv_q,
   output logic [IV_W-1:0] cnt_q,
   output logic            run_q,
   output logic            tmo_q
);
   localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
   localparam logic [IV_W-1:0]  ONE      = IV_W'(1);

   logic [DIV_W-1:0] div_q;
   logic             qtick;

   assign qtick = run_q & lf_pulse & (div_q == DIV_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) iv_q <= '0;
      else if (iv_wr) iv_q <= iv_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         div_q <= '0;
         tmo_q <= 1'b0;
      end else begin
         tmo_q <= 1'b0;
         if (go) begin
            cnt_q <= iv_q;
            run_q <= 1'b1;
            div_q <= '0;
         end else if (halt) begin
            run_q <= 1'b0;
         end else if (run_q && lf_pulse) begin
            if (qtick) begin
               div_q <= '0;
               if (cnt_q <= ONE) begin
                  cnt_q <= '0;
                  run_q <= 1'b0;
                  tmo_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end else begin
               div_q <= div_q + DIV_W'(1);
            end
         end
      end
   end

   // R4
   tmo_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |-> (!run_q && cnt_q == '0));
   // R3
   tmo_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |-> $past(run_q));
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !go) |=> $stable(cnt_q));
endmodule

// File: rtl/lfrc_cal_window.sv
module lfrc_cal_window #(
   parameter int CAL_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open,
   input  logic hfxo_running,
   output logic busy_q,
   output logic done_q,
   output logic ok_q
);
   localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

   logic [CNT_W-1:0] left_q;
   logic             good_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         left_q <= '0;
         good_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (open && !busy_q) begin
            busy_q <= 1'b1;
            left_q <= LAST;
            good_q <= 1'b1;
         end else if (busy_q) begin
            good_q <= good_q & hfxo_running;
            if (left_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               ok_q   <= good_q & hfxo_running;
            end else begin
               left_q <= left_q - CNT_W'(1);
            end
         end
      end
   end

   // R9
   done_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));
   // R9
   window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open && !busy_q) |=> busy_q);
   // R10
   ok_needs_xo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && ok_q) |-> $past(hfxo_running));
endmodule

// File: rtl/lfrc_irq_regs.sv
module lfrc_irq_regs
   import lfrc_cal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] ev,
   input  logic             set_wr,
   input  logic             clr_wr,
   input  logic [EVT_W-1:0] en_wdata,
   input  logic             pclr_wr,
   input  logic [EVT_W-1:0] pclr_mask,
   output logic [EVT_W-1:0] en_q,
   output logic [EVT_W-1:0] pend_q,
   output logic             irq
);
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (EVT_IMPL[i]) begin : g_impl
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q[i]   <= 1'b0;
               pend_q[i] <= 1'b0;
            end else begin
               if (clr_wr && en_wdata[i])      en_q[i] <= 1'b0;
               else if (set_wr && en_wdata[i]) en_q[i] <= 1'b1;
               if (ev[i])                        pend_q[i] <= 1'b1;
               else if (pclr_wr && pclr_mask[i]) pend_q[i] <= 1'b0;
            end
         end
         // R12
         pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> pend_q[i]);
         // R11
         en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && en_wdata[i]) |=> !en_q[i]);
      end else begin : g_rsvd
         logic unused_rsvd;
         assign unused_rsvd = ^{ev[i], en_wdata[i], pclr_mask[i]};
         assign en_q[i]   = 1'b0;
         assign pend_q[i] = 1'b0;
      end
   end

   assign irq = |(en_q & pend_q);
endmodule

// File: rtl/lfrc_cal_sched.sv
module lfrc_cal_sched
   import lfrc_cal_pkg::*;
#(
   parameter int IV_W       = 7,
   parameter int DIV_RATIO  = 8192,
   parameter int CAL_CYCLES = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lf_pulse,
   input  logic            hfxo_running,
   input  logic            hf_started_in,
   input  logic            lf_started_in,
   input  logic            task_cal,
   input  logic            task_ct_start,
   input  logic            task_ct_stop,
   input  logic            interval_wr,
   input  logic [IV_W-1:0] interval_wdata,
   input  logic            inten_set_wr,
   input  logic            inten_clr_wr,
   input  logic [4:0]      inten_wdata,
   input  logic            evt_clr_wr,
   input  logic [4:0]      evt_clr_mask,
   output logic [IV_W-1:0] interval_q,
   output logic [IV_W-1:0] ct_count,
   output logic            ct_running,
   output logic            timeout_evt,
   output logic            hf_req,
   output logic            done_evt,
   output logic            cal_ok,
   output logic [4:0]      inten,
   output logic [4:0]      pending,
   output logic            irq,
   output logic            task_err
);
   if (DIV_RATIO < 2) begin : g_bad_div
      $error("DIV_RATIO must be at least 2");
   end
   if (CAL_CYCLES < 1) begin : g_bad_cal
      $error("CAL_CYCLES must be at least 1");
   end
   if (IV_W < 1 || IV_W > 16) begin : g_bad_iv
      $error("IV_W must lie in 1..16");
   end

   task_vec_t        req;
   task_vec_t        grant;
   logic [EVT_W-1:0] ev;

   assign req = '{stop: task_ct_stop, start: task_ct_start, cal: task_cal};

   lfrc_task_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .lf_pulse (lf_pulse),
      .req      (req),
      .grant    (grant),
      .err      (task_err)
   );

   lfrc_interval_timer #(
      .IV_W      (IV_W),
      .DIV_RATIO (DIV_RATIO)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .lf_pulse (lf_pulse),
      .iv_wr    (interval_wr),
      .iv_wdata (interval_wdata),
      .go       (grant.start),
      .halt     (grant.stop),
      .iv_q     (interval_q),
      .cnt_q    (ct_count),
      .run_q    (ct_running),
      .tmo_q    (timeout_evt)
   );

   lfrc_cal_window #(
      .CAL_CYCLES (CAL_CYCLES)
   ) u_cal (
      .clk          (clk),
      .rst_n        (rst_n),
      .open         (grant.cal),
      .hfxo_running (hfxo_running),
      .busy_q       (hf_req),
      .done_q       (done_evt),
      .ok_q         (cal_ok)
   );

   always_comb begin
      ev = '0;
      ev[BIT_HF_START] = hf_started_in;
      ev[BIT_LF_START] = lf_started_in;
      ev[BIT_CAL_DONE] = done_evt;
      ev[BIT_TIMEOUT]  = timeout_evt;
   end

   lfrc_irq_regs u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .set_wr    (inten_set_wr),
      .clr_wr    (inten_clr_wr),
      .en_wdata  (inten_wdata),
      .pclr_wr   (evt_clr_wr),
      .pclr_mask (evt_clr_mask),
      .en_q      (inten),
      .pend_q    (pending),
      .irq       (irq)
   );

   // R9
   no_cal_while_err_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (task_cal && (task_ct_start || task_ct_stop) && !hf_req) |=> !hf_req);
endmodule

// File: tb/lfrc_cal_sched_bench.sv
module lfrc_cal_sched_bench;
   localparam int DIV = 4;
   localparam int CAL = 8;
   localparam int ROWS = 6;
   localparam int VEC_IV [ROWS]   = '{0, 1, 2, 3, 7, 20};
   localparam int VEC_TICK [ROWS] = '{1, 1, 2, 3, 7, 20};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lf_pulse = 1'b0, hfxo_running = 1'b0;
   logic hf_started_in = 1'b0, lf_started_in = 1'b0;
   logic task_cal = 1'b0, task_ct_start = 1'b0, task_ct_stop = 1'b0;
   logic interval_wr = 1'b0;
   logic [6:0] interval_wdata = '0;
   logic inten_set_wr = 1'b0, inten_clr_wr = 1'b0, evt_clr_wr = 1'b0;
   logic [4:0] inten_wdata = '0, evt_clr_mask = '0;
   logic [6:0] interval_q, ct_count;
   logic ct_running, timeout_evt, hf_req, done_evt, cal_ok, irq, task_err;
   logic [4:0] inten, pending;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   lfrc_cal_sched #(.IV_W(7), .DIV_RATIO(DIV), .CAL_CYCLES(CAL)) u_lfrc_cal_sched (
      .clk(clk), .rst_n(rst_n), .lf_pulse(lf_pulse), .hfxo_running(hfxo_running),
      .hf_started_in(hf_started_in), .lf_started_in(lf_started_in),
      .task_cal(task_cal), .task_ct_start(task_ct_start), .task_ct_stop(task_ct_stop),
      .interval_wr(interval_wr), .interval_wdata(interval_wdata),
      .inten_set_wr(inten_set_wr), .inten_clr_wr(inten_clr_wr), .inten_wdata(inten_wdata),
      .evt_clr_wr(evt_clr_wr), .evt_clr_mask(evt_clr_mask),
      .interval_q(interval_q), .ct_count(ct_count), .ct_running(ct_running),
      .timeout_evt(timeout_evt), .hf_req(hf_req), .done_evt(done_evt), .cal_ok(cal_ok),
      .inten(inten), .pending(pending), .irq(irq), .task_err(task_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic lf_step();
      @(negedge clk); lf_pulse = 1'b1;
      @(negedge clk); lf_pulse = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic fire(input logic c, input logic s, input logic p);
      @(negedge clk);
      task_cal = c; task_ct_start = s; task_ct_stop = p;
      @(negedge clk);
      task_cal = 1'b0; task_ct_start = 1'b0; task_ct_stop = 1'b0;
   endtask

   task automatic wr_iv(input int v);
      @(negedge clk); interval_wr = 1'b1; interval_wdata = 7'(v);
      @(negedge clk); interval_wr = 1'b0;
   endtask

   task automatic en_write(input logic s, input logic c, input logic [4:0] m);
      @(negedge clk); inten_set_wr = s; inten_clr_wr = c; inten_wdata = m;
      @(negedge clk); inten_set_wr = 1'b0; inten_clr_wr = 1'b0;
   endtask

   task automatic clr_evt(input logic [4:0] m);
      @(negedge clk); evt_clr_wr = 1'b1; evt_clr_mask = m;
      @(negedge clk); evt_clr_wr = 1'b0;
   endtask

   task automatic run_cal(output int width);
      fire(1'b1, 1'b0, 1'b0);
      width = 0;
      while (hf_req && width < 10 * CAL) begin
         width++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int n;
      int w;
      do_reset();
      // R1 reset state
      chk("R1", "ct_count", ct_count, 0);
      chk("R1", "interval_q", interval_q, 0);
      chk("R1", "ct_running", ct_running, 0);
      chk("R1", "inten", inten, 0);
      chk("R1", "pending", pending, 0);
      chk("R1", "irq/hf_req/err", {irq, hf_req, task_err, done_evt, timeout_evt}, 0);

      // vector table: interval -> ticks to timeout (R2, R3, R4, R6)
      for (int r = 0; r < ROWS; r++) begin
         wr_iv(VEC_IV[r]);
         chk("R2", "interval_q", interval_q, VEC_IV[r]);
         lf_step();
         clr_evt(5'b11111);
         fire(1'b0, 1'b1, 1'b0);
         chk("R2", "ct_count loaded", ct_count, VEC_IV[r]);
         chk("R2", "ct_running", ct_running, 1);
         n = 0;
         while (!pending[4] && n < 200 * DIV) begin
            lf_step();
            n++;
         end
         if (VEC_IV[r] == 0) chk("R6", "strobes to timeout, zero interval", n, DIV);
         else                chk("R3", "strobes to timeout", n, VEC_TICK[r] * DIV);
         chk("R4", "ct_running after timeout", ct_running, 0);
         chk("R4", "ct_count after timeout", ct_count, 0);
      end
      clr_evt(5'b11111);
      repeat (3 * DIV) lf_step();
      chk("R4", "no second timeout", pending[4], 0);

      // R5 stop freezes count
      wr_iv(5);
      lf_step();
      fire(1'b0, 1'b1, 1'b0);
      repeat (DIV + 2) lf_step();
      chk("R5", "count after one tick", ct_count, 4);
      fire(1'b0, 1'b0, 1'b1);
      chk("R5", "ct_running after stop", ct_running, 0);
      repeat (6 * DIV) lf_step();
      chk("R5", "count frozen", ct_count, 4);
      chk("R5", "no timeout after stop", pending[4], 0);

      // R7 second request in one period
      chk("R7", "task_err before", task_err, 0);
      lf_step();
      fire(1'b0, 1'b1, 1'b0);
      fire(1'b0, 1'b0, 1'b1);
      chk("R7", "late stop ignored", ct_running, 1);
      chk("R7", "task_err set", task_err, 1);
      lf_step();
      chk("R7", "task_err sticky", task_err, 1);

      // R8 same-cycle priority
      do_reset();
      wr_iv(5);
      lf_step();
      fire(1'b0, 1'b1, 1'b0);
      repeat (DIV + 1) lf_step();
      chk("R8", "count before clash", ct_count, 4);
      fire(1'b1, 1'b1, 1'b0);
      chk("R8", "start wins, reload", ct_count, 5);
      chk("R8", "cal dropped", hf_req, 0);
      chk("R8", "task_err", task_err, 1);
      lf_step();
      fire(1'b1, 1'b0, 1'b1);
      chk("R8", "stop wins over cal", {ct_running, hf_req}, 0);

      // R9 / R10 calibration
      do_reset();
      hfxo_running = 1'b1;
      lf_step();
      run_cal(w);
      chk("R9", "hf_req width", w, CAL);
      chk("R9", "done_evt after window", done_evt, 1);
      @(negedge clk);
      chk("R9", "done pending", pending[3], 1);
      chk("R10", "cal_ok with crystal", cal_ok, 1);
      lf_step();
      fire(1'b1, 1'b0, 1'b0);
      @(negedge clk); hfxo_running = 1'b0;
      @(negedge clk); hfxo_running = 1'b1;
      n = 0;
      while (!done_evt && n < 10 * CAL) begin
         n++;
         @(negedge clk);
      end
      chk("R10", "done still signalled", done_evt, 1);
      chk("R10", "cal_ok without crystal", cal_ok, 0);

      // R11 enable bits
      en_write(1'b1, 1'b0, 5'b11111);
      chk("R11", "set all, bit 2 reserved", inten, 5'b11011);
      chk("R12", "irq from done", irq, 1);
      en_write(1'b0, 1'b1, 5'b00001);
      chk("R11", "clear bit 0", inten, 5'b11010);
      en_write(1'b1, 1'b1, 5'b00001);
      chk("R11", "clear wins over set", inten, 5'b11010);

      // R12 pending and irq
      clr_evt(5'b11111);
      chk("R12", "pending cleared", pending, 0);
      chk("R12", "irq low", irq, 0);
      @(negedge clk); hf_started_in = 1'b1;
      @(negedge clk); hf_started_in = 1'b0;
      chk("R12", "hf started pending", pending, 5'b00001);
      chk("R12", "irq masked", irq, 0);
      en_write(1'b1, 1'b0, 5'b00001);
      chk("R12", "irq enabled", irq, 1);
      @(negedge clk); lf_started_in = 1'b1;
      @(negedge clk); lf_started_in = 1'b0;
      chk("R12", "lf started pending", pending, 5'b00011);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule